// File: doc/BRIEF.md
# Card Command Issue and Response Capture Engine

This block sits between a register file and the card-side command path of a memory-card host controller. Software loads a 32-bit argument and then writes a command word. If that word has its enable bit set, and neither of the two unsupported modes is selected, the block sends a one-cycle request to the card side carrying the command index and the argument. When the command expects a reply, the card side returns the reply as a stream of bytes followed by a done pulse.

The block packs those bytes big-endian into four 32-bit response words. It judges the reply length against what the command asked for and raises exactly one sticky completion flag: reply received, command sent with no reply, or timeout. The enable bit of the stored command clears itself when the command finishes. An active flag covers the whole time a command is in flight.

Top module: `cmdrsp_engine`

## Requirements
- R1: The command word holds the index in bits 5:0, reply-expected in bit 6, long-reply in bit 7, interrupt mode in bit 8, pending mode in bit 9 and enable in bit 10. A write with bit 10 set and bits 8 and 9 clear raises `req_valid` for exactly one cycle, in the cycle after the write, with `req_index` equal to bits 5:0.
- R2: A write to the argument register is visible on `arg_word` in the next cycle, and `req_arg` carries that register during the request.
- R3: Reply bytes are packed with the first received byte in bits 31:24 of a word and the fourth in bits 7:0.
- R4: A valid short reply has exactly 4 bytes and no long reply requested. It loads word 0 with those bytes and sets words 1 to 3 to zero.
- R5: A 16-byte reply loads words 0 to 3 in arrival order, whatever bit 7 says, and forces bit 0 of word 3 to zero.
- R6: When a reply is expected, a byte count of 0, a count of 4 with a long reply requested, or any count other than 4 and 16 (more than 16 included) raises the timeout flag and leaves the response words unchanged.
- R7: A valid reply raises the reply-received flag on the done cycle. A command without a reply raises the command-sent flag one cycle after its request. Only one flag is raised per command.
- R8: Bit 10 of `cmd_word` reads 1 while a command is in flight and reads 0 from the cycle in which a completion flag is raised.
- R9: `st_active` is 1 from the request cycle until a completion flag is raised, and 0 in that completion cycle.
- R10: A command written with enable and with bit 8 or bit 9 set sends no request and raises no flag. It is stored with bit 10 reading 0.
- R11: Writes to the command or argument register while a command is in flight are ignored.
- R12: The flags stay set until cleared through `stat_clr` (bit 0 reply-received, bit 1 command-sent, bit 2 timeout). When a flag is set and cleared in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 11 | Command word to write |
| arg_wr | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument to write |
| stat_clr | input | 3 | Per-flag clear strobes |
| req_valid | output | 1 | One-cycle request to the card side |
| req_index | output | 6 | Command index of the request |
| req_arg | output | 32 | Argument of the request |
| rsp_byte_valid | input | 1 | A reply byte is present |
| rsp_byte | input | 8 | Reply byte |
| rsp_done | input | 1 | Reply finished (a byte in the same cycle counts) |
| cmd_word | output | 11 | Stored command word |
| arg_word | output | 32 | Stored argument |
| resp_words | output | 128 | Response words, word i at bits 32*i+31:32*i |
| st_resp_end | output | 1 | Reply received flag |
| st_cmd_sent | output | 1 | Command sent without reply flag |
| st_timeout | output | 1 | Timeout flag |
| st_active | output | 1 | Command in flight |

## Verification
Two events can land on the same edge: completion, which raises a flag, and a software clear of that same flag. The bench provokes this by driving all three `stat_clr` bits on the edge that carries `rsp_done`, sometimes with the final byte on that edge as well. It then expects the new flag to read set and the others to read clear, and it expects a later separate clear to drop the flag. A second overlap comes from a final byte and the done pulse arriving on the same edge. For that case the bench builds its expected words from a byte count that includes the final byte.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;
   typedef enum logic [1:0] {
      CR_IDLE  = 2'd0,
      CR_ISSUE = 2'd1,
      CR_WAIT  = 2'd2
   } cr_state_t;

   localparam int ST_RESP_END = 0;
   localparam int ST_SENT     = 1;
   localparam int ST_TOUT     = 2;
   localparam int ST_N        = 3;
endpackage

// File: rtl/cmdrsp_collect.sv
module cmdrsp_collect #(
   parameter int BYTE_W    = 8,
   parameter int MAX_BYTES = 16,
   parameter int CNT_W     = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr,
   input  logic                          take,
   input  logic [BYTE_W-1:0]             byte_in,
   output logic [MAX_BYTES*BYTE_W-1:0]   shift_nx,
   output logic [CNT_W-1:0]              cnt_nx
);
   localparam int SH_W = MAX_BYTES*BYTE_W;
   localparam int SAT  = MAX_BYTES + 1;

   logic [SH_W-1:0]  sh_q;
   logic [CNT_W-1:0] cnt_q;

   // newest byte enters at the bottom, so the first byte drifts to the top
   assign shift_nx = take ? {sh_q[SH_W-BYTE_W-1:0], byte_in} : sh_q;
   assign cnt_nx   = (take && (cnt_q != CNT_W'(SAT))) ? cnt_q + 1'b1 : cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else begin
         sh_q  <= shift_nx;
         cnt_q <= cnt_nx;
      end
   end
endmodule

// File: rtl/cmdrsp_classify.sv
module cmdrsp_classify #(
   parameter int SHORT_BYTES = 4,
   parameter int LONG_BYTES  = 16,
   parameter int CNT_W       = 5
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic             want_long,
   output logic             fmt_short,
   output logic             fmt_long,
   output logic             fmt_bad
);
   assign fmt_short = (cnt == CNT_W'(SHORT_BYTES)) && !want_long;
   assign fmt_long  = (cnt == CNT_W'(LONG_BYTES));
   assign fmt_bad   = !(fmt_short || fmt_long);
endmodule

// File: rtl/cmdrsp_pack.sv
module cmdrsp_pack #(
   parameter int WORD_W    = 32,
   parameter int RSP_WORDS = 4
) (
   input  logic [WORD_W*RSP_WORDS-1:0] shift_in,
   input  logic                        is_long,
   output logic [WORD_W*RSP_WORDS-1:0] words
);
   for (genvar i = 0; i < RSP_WORDS; i++) begin : g_word
      logic [WORD_W-1:0] lw;
      if (i == RSP_WORDS-1) begin : g_last
         assign lw = {shift_in[WORD_W-1:1], 1'b0};
      end else begin : g_mid
         assign lw = shift_in[(RSP_WORDS-1-i)*WORD_W +: WORD_W];
      end
      if (i == 0) begin : g_first
         assign words[0 +: WORD_W] = is_long ? lw : shift_in[WORD_W-1:0];
      end else begin : g_rest
         assign words[i*WORD_W +: WORD_W] = is_long ? lw : '0;
      end
   end
endmodule

// File: rtl/cmdrsp_engine.sv
module cmdrsp_engine #(
   parameter int IDX_W     = 6,
   parameter int ARG_W     = 32,
   parameter int WORD_W    = 32,
   parameter int RSP_WORDS = 4,
   parameter int BYTE_W    = 8,
   localparam int CMD_W    = IDX_W + 5,
   localparam int RSP_W    = WORD_W * RSP_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_wdata,
   input  logic              arg_wr,
   input  logic [ARG_W-1:0]  arg_wdata,
   input  logic [2:0]        stat_clr,
   output logic              req_valid,
   output logic [IDX_W-1:0]  req_index,
   output logic [ARG_W-1:0]  req_arg,
   input  logic              rsp_byte_valid,
   input  logic [BYTE_W-1:0] rsp_byte,
   input  logic              rsp_done,
   output logic [CMD_W-1:0]  cmd_word,
   output logic [ARG_W-1:0]  arg_word,
   output logic [RSP_W-1:0]  resp_words,
   output logic              st_resp_end,
   output logic              st_cmd_sent,
   output logic              st_timeout,
   output logic              st_active
);
   import cmdrsp_pkg::*;

   localparam int SHORT_BYTES = WORD_W / BYTE_W;
   localparam int LONG_BYTES  = SHORT_BYTES * RSP_WORDS;
   localparam int CNT_W       = $clog2(LONG_BYTES + 2);
   localparam int B_RSP  = IDX_W;
   localparam int B_LONG = IDX_W + 1;
   localparam int B_INT  = IDX_W + 2;
   localparam int B_PEND = IDX_W + 3;
   localparam int B_EN   = IDX_W + 4;

   if ((WORD_W % BYTE_W) != 0 || RSP_WORDS < 2 || IDX_W < 1) begin : g_bad_cfg
      $error("cmdrsp_engine: word width must be whole bytes and at least two response words");
   end

   cr_state_t              state_q;
   logic [CMD_W-1:0]       cmd_q;
   logic [ARG_W-1:0]       arg_q;
   logic [RSP_W-1:0]       resp_q;
   logic [ST_N-1:0]        st_q, st_set;
   logic                   active_q;
   logic [RSP_W-1:0]       shift_nx, packed_words;
   logic [CNT_W-1:0]       cnt_nx;
   logic                   fmt_short, fmt_long, fmt_bad;
   logic                   w_go, finish_rsp;

   cmdrsp_collect #(.BYTE_W(BYTE_W), .MAX_BYTES(LONG_BYTES), .CNT_W(CNT_W)) u_collect (
      .clk(clk), .rst_n(rst_n),
      .clr(state_q == CR_ISSUE),
      .take((state_q == CR_WAIT) && rsp_byte_valid),
      .byte_in(rsp_byte),
      .shift_nx(shift_nx), .cnt_nx(cnt_nx)
   );

   cmdrsp_classify #(.SHORT_BYTES(SHORT_BYTES), .LONG_BYTES(LONG_BYTES), .CNT_W(CNT_W)) u_class (
      .cnt(cnt_nx), .want_long(cmd_q[B_LONG]),
      .fmt_short(fmt_short), .fmt_long(fmt_long), .fmt_bad(fmt_bad)
   );

   cmdrsp_pack #(.WORD_W(WORD_W), .RSP_WORDS(RSP_WORDS)) u_pack (
      .shift_in(shift_nx), .is_long(fmt_long), .words(packed_words)
   );

   assign w_go       = cmd_wdata[B_EN] && !cmd_wdata[B_INT] && !cmd_wdata[B_PEND];
   assign finish_rsp = (state_q == CR_WAIT) && rsp_done;

   always_comb begin
      st_set              = '0;
      st_set[ST_SENT]     = (state_q == CR_ISSUE) && !cmd_q[B_RSP];
      st_set[ST_RESP_END] = finish_rsp && !fmt_bad;
      st_set[ST_TOUT]     = finish_rsp && fmt_bad;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= CR_IDLE;
         cmd_q    <= '0;
         arg_q    <= '0;
         resp_q   <= '0;
         st_q     <= '0;
         active_q <= 1'b0;
      end else begin
         st_q <= (st_q & ~stat_clr) | st_set;
         unique case (state_q)
            CR_IDLE: begin
               if (arg_wr) arg_q <= arg_wdata;
               if (cmd_wr) begin
                  if (w_go) begin
                     cmd_q    <= cmd_wdata;
                     state_q  <= CR_ISSUE;
                     active_q <= 1'b1;
                  end else begin
                     cmd_q        <= cmd_wdata;
                     cmd_q[B_EN]  <= 1'b0;
                  end
               end
            end
            CR_ISSUE: begin
               if (!cmd_q[B_RSP]) begin
                  state_q     <= CR_IDLE;
                  cmd_q[B_EN] <= 1'b0;
                  active_q    <= 1'b0;
               end else begin
                  state_q <= CR_WAIT;
               end
            end
            CR_WAIT: begin
               if (rsp_done) begin
                  state_q     <= CR_IDLE;
                  cmd_q[B_EN] <= 1'b0;
                  active_q    <= 1'b0;
                  if (!fmt_bad) resp_q <= packed_words;
               end
            end
            default: state_q <= CR_IDLE;
         endcase
      end
   end

   assign req_valid   = (state_q == CR_ISSUE);
   assign req_index   = cmd_q[IDX_W-1:0];
   assign req_arg     = arg_q;
   assign cmd_word    = cmd_q;
   assign arg_word    = arg_q;
   assign resp_words  = resp_q;
   assign st_resp_end = st_q[ST_RESP_END];
   assign st_cmd_sent = st_q[ST_SENT];
   assign st_timeout  = st_q[ST_TOUT];
   assign st_active   = active_q;
endmodule

// File: rtl/cmdrsp_engine_chk.sv
module cmdrsp_engine_chk #(
   parameter int IDX_W     = 6,
   parameter int WORD_W    = 32,
   parameter int RSP_WORDS = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        req_valid,
   input logic                        st_active,
   input logic                        st_resp_end,
   input logic                        st_cmd_sent,
   input logic                        st_timeout,
   input logic [2:0]                  stat_clr,
   input logic [IDX_W+4:0]            cmd_word,
   input logic [WORD_W*RSP_WORDS-1:0] resp_words
);
   localparam int LAST_LSB = (RSP_WORDS-1)*WORD_W;

   // R1: the request lasts a single cycle
   a_r1_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !req_valid);

   // R9: a request is only seen while the block is active
   a_r9_req_active: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> st_active);

   // R8: each completion leaves the enable bit clear and the block idle
   a_r8_done_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(st_resp_end) || $rose(st_cmd_sent) || $rose(st_timeout))
      |-> (!cmd_word[IDX_W+4] && !st_active));

   // R7: at most one outcome per completion
   a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({$rose(st_resp_end), $rose(st_cmd_sent), $rose(st_timeout)}) <= 1);

   // R5: the low bit of the last response word never reads 1
   a_r5_last_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_words[LAST_LSB]);

   // R6: a timeout leaves the response words unchanged
   a_r6_timeout_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_timeout) |-> $stable(resp_words));

   // R12: a flag holds until it is cleared
   a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (st_resp_end && !stat_clr[0]) |=> st_resp_end);
endmodule

bind cmdrsp_engine cmdrsp_engine_chk #(.IDX_W(IDX_W), .WORD_W(WORD_W), .RSP_WORDS(RSP_WORDS)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .st_active(st_active),
   .st_resp_end(st_resp_end), .st_cmd_sent(st_cmd_sent), .st_timeout(st_timeout),
   .stat_clr(stat_clr), .cmd_word(cmd_word), .resp_words(resp_words)
);

// File: tb/cmdrsp_engine_test.sv
module cmdrsp_engine_test;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         cmd_wr, arg_wr, rsp_byte_valid, rsp_done;
   logic [10:0]  cmd_wdata;
   logic [31:0]  arg_wdata;
   logic [2:0]   stat_clr;
   logic [7:0]   rsp_byte;
   logic         req_valid, st_resp_end, st_cmd_sent, st_timeout, st_active;
   logic [5:0]   req_index;
   logic [31:0]  req_arg, arg_word;
   logic [10:0]  cmd_word;
   logic [127:0] resp_words;

   int checks = 0;
   int fails  = 0;
   logic [127:0] exp_words = '0;

   always #10 clk = ~clk;

   cmdrsp_engine uut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .arg_wr(arg_wr), .arg_wdata(arg_wdata), .stat_clr(stat_clr),
      .req_valid(req_valid), .req_index(req_index), .req_arg(req_arg),
      .rsp_byte_valid(rsp_byte_valid), .rsp_byte(rsp_byte), .rsp_done(rsp_done),
      .cmd_word(cmd_word), .arg_word(arg_word), .resp_words(resp_words),
      .st_resp_end(st_resp_end), .st_cmd_sent(st_cmd_sent),
      .st_timeout(st_timeout), .st_active(st_active)
   );

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic run_cmd(input logic [5:0] idx, input bit want, input bit lng,
                          input bit intr, input bit pend, input int n,
                          input bit done_last, input bit collide);
      logic [7:0]   b [20];
      logic [31:0]  a;
      logic [10:0]  c;
      logic [127:0] nw;
      bit           tout;
      a = $urandom;
      for (int i = 0; i < 20; i++) b[i] = 8'($urandom);
      c = {1'b1, pend, intr, lng, want, idx};

      stat_clr = 3'b111; step(); stat_clr = 3'b000;
      chk({st_resp_end, st_cmd_sent, st_timeout} == 3'b000, "R12 clear", 128'({st_resp_end, st_cmd_sent, st_timeout}), 0);

      arg_wr = 1'b1; arg_wdata = a; step(); arg_wr = 1'b0;
      chk(arg_word == a, "R2 arg write", 128'(arg_word), 128'(a));

      cmd_wr = 1'b1; cmd_wdata = c; step(); cmd_wr = 1'b0;
      if (intr || pend) begin
         chk(!req_valid, "R10 no request", 128'(req_valid), 0);
         chk(cmd_word == (c & 11'h3ff), "R10 enable dropped", 128'(cmd_word), 128'(c & 11'h3ff));
         step();
         chk({st_resp_end, st_cmd_sent, st_timeout, st_active, req_valid} == 5'b0, "R10 no flags",
             128'({st_resp_end, st_cmd_sent, st_timeout, st_active, req_valid}), 0);
         return;
      end
      chk(req_valid && req_index == idx, "R1 request index", 128'({req_valid, req_index}), 128'({1'b1, idx}));
      chk(req_arg == a, "R2 request arg", 128'(req_arg), 128'(a));
      chk(st_active, "R9 active at request", 128'(st_active), 1);
      chk(cmd_word[10], "R8 enable held", 128'(cmd_word), 128'(c));

      // writes during the request cycle must be dropped
      cmd_wr = 1'b1; cmd_wdata = {1'b0, ~c[9:0]}; arg_wr = 1'b1; arg_wdata = ~a;
      step(); cmd_wr = 1'b0; arg_wr = 1'b0;
      chk(arg_word == a, "R11 arg kept", 128'(arg_word), 128'(a));
      chk(cmd_word[9:0] == c[9:0], "R11 cmd kept", 128'(cmd_word), 128'(c));
      chk(!req_valid, "R1 single request", 128'(req_valid), 0);

      if (!want) begin
         chk({st_resp_end, st_cmd_sent, st_timeout} == 3'b010, "R7 cmd sent", 128'({st_resp_end, st_cmd_sent, st_timeout}), 128'(3'b010));
         chk(!st_active && !cmd_word[10], "R8 R9 done no reply", 128'({st_active, cmd_word[10]}), 0);
         return;
      end
      chk(st_active && cmd_word[10], "R9 active waiting", 128'({st_active, cmd_word[10]}), 128'(2'b11));

      for (int i = 0; i < n; i++) begin
         rsp_byte_valid = 1'b1; rsp_byte = b[i];
         if (i == n-1 && done_last) begin
            rsp_done = 1'b1;
            if (collide) stat_clr = 3'b111;
         end
         step();
         rsp_byte_valid = 1'b0; rsp_done = 1'b0; stat_clr = 3'b000;
         if (!(i == n-1 && done_last) && ($urandom % 3 == 0)) begin
            step();
            chk(st_active, "R9 active mid reply", 128'(st_active), 1);
         end
      end
      if (!(n > 0 && done_last)) begin
         rsp_done = 1'b1;
         if (collide) stat_clr = 3'b111;
         step();
         rsp_done = 1'b0; stat_clr = 3'b000;
      end

      tout = 1'b1;
      nw   = exp_words;
      if (n == 4 && !lng) begin
         tout = 1'b0;
         nw   = {96'd0, b[0], b[1], b[2], b[3]};
      end else if (n == 16) begin
         tout = 1'b0;
         for (int w = 0; w < 4; w++) nw[w*32 +: 32] = {b[4*w], b[4*w+1], b[4*w+2], b[4*w+3]};
         nw[96] = 1'b0;
      end
      exp_words = nw;
      if (tout)
         chk({st_resp_end, st_cmd_sent, st_timeout} == 3'b001, "R6 timeout flag", 128'({st_resp_end, st_cmd_sent, st_timeout}), 1);
      else
         chk({st_resp_end, st_cmd_sent, st_timeout} == 3'b100, "R7 R12 reply flag", 128'({st_resp_end, st_cmd_sent, st_timeout}), 128'(3'b100));
      chk(resp_words == exp_words, n == 16 ? "R5 R3 long words" : (tout ? "R6 words kept" : "R4 R3 short words"), resp_words, exp_words);
      chk(!st_active && !cmd_word[10], "R8 R9 done reply", 128'({st_active, cmd_word[10]}), 0);
      if (collide) begin
         stat_clr = 3'b111; step(); stat_clr = 3'b000;
         chk({st_resp_end, st_cmd_sent, st_timeout} == 3'b000, "R12 later clear", 128'({st_resp_end, st_cmd_sent, st_timeout}), 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; cmd_wr = 1'b0; arg_wr = 1'b0; rsp_byte_valid = 1'b0; rsp_done = 1'b0;
      cmd_wdata = '0; arg_wdata = '0; stat_clr = '0; rsp_byte = '0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk({req_valid, st_resp_end, st_cmd_sent, st_timeout, st_active} == 5'b0, "R9 reset flags",
          128'({req_valid, st_resp_end, st_cmd_sent, st_timeout, st_active}), 0);
      chk(cmd_word == 0 && arg_word == 0 && resp_words == 0, "R1 reset regs", resp_words, 0);

      run_cmd(6'd17, 1, 0, 0, 0, 4,  0, 0);   // short reply
      run_cmd(6'd2,  1, 1, 0, 0, 16, 0, 0);   // long reply
      run_cmd(6'd9,  1, 1, 0, 0, 16, 1, 1);   // done with last byte, clear collides
      run_cmd(6'd0,  1, 0, 0, 0, 0,  0, 0);   // no bytes
      run_cmd(6'd41, 1, 1, 0, 0, 4,  0, 0);   // short where long expected
      run_cmd(6'd5,  1, 0, 0, 0, 5,  0, 0);   // odd length
      run_cmd(6'd7,  1, 0, 0, 0, 17, 1, 0);   // too long
      run_cmd(6'd3,  1, 0, 0, 0, 16, 0, 1);   // long reply though short asked
      run_cmd(6'd63, 0, 0, 0, 0, 0,  0, 0);   // no reply expected
      run_cmd(6'd12, 1, 0, 1, 0, 4,  0, 0);   // interrupt mode
      run_cmd(6'd13, 1, 0, 0, 1, 4,  0, 0);   // pending mode
      run_cmd(6'd21, 1, 0, 0, 0, 4,  1, 1);   // short, done with last byte, collide

      for (int t = 0; t < 60; t++) begin
         int k, n;
         k = int'($urandom % 6);
         n = (k == 0) ? 0 : (k == 1) ? 4 : (k < 4) ? 16 : (k == 4) ? int'($urandom % 20) : 17;
         run_cmd(6'($urandom), ($urandom % 5) != 0, $urandom % 2 == 1,
                 ($urandom % 10) == 0, ($urandom % 10) == 0, n,
                 $urandom % 2 == 1, $urandom % 3 == 0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule